// File: doc/BRIEF.md
# Firmware Image Header Validator

The block takes in a firmware image one byte at a time and decides whether the image can be used. A load starts with a one-cycle `start` pulse that carries the image length. The image bytes then arrive over a valid/ready stream and are kept in an internal byte buffer, so the header can later be read from any position in the image. While the bytes arrive, the block computes a 16-bit CRC over every byte except the last two. The last two bytes are captured as the expected checksum.

Once the whole image is in the buffer, a sequencer reads a 16-bit little-endian word at a fixed position and scales it into a relocation base. It then reads a section header placed at that base plus a fixed distance. The header gives the offset and size of a code section and of a data section. The block checks that each read stays inside the image, that each section size is a whole number of 32-bit words, and that each section lies inside the image.

When the checks finish, the block raises a one-cycle `done` pulse and holds a pass flag, an error code and the resolved section offsets and sizes until the next load. The image length must not exceed the buffer capacity, which is 2^ADDR_W bytes.

Top module: `fw_image_checker`

## Requirements
- R1: The checksum is CRC-16 with polynomial 0x1021, initial value 0x0000, no bit reflection and no final XOR. It is computed over bytes 0 to len-3. The expected value is big-endian: byte len-2 is the high byte and byte len-1 is the low byte. A mismatch gives error code 1.
- R2: The relocation base is the little-endian word at bytes 8 (low) and 9 (high), shifted left by 12. Error code 2 is reported in either of two cases: the word read does not fit (10 > len), or the 16-byte header at base + 0x300 does not fit (base + 0x310 > len).
- R3: The header starts with 4 pad bytes. Four 3-byte little-endian fields follow: code offset at header+4, code size at header+7, data offset at header+10 and data size at header+13. On a pass, `code_off` and `data_off` equal the field plus the base, and the sizes equal the fields.
- R4: A code or data size that is not a multiple of 4 gives error code 3.
- R5: A section whose resolved offset plus size exceeds len gives error code 4. Ending exactly at len is accepted, and the 24-bit fields never wrap.
- R6: Only the first failure is reported, in this order: CRC, word/header bounds, code alignment, code bounds, data alignment, data bounds.
- R7: A length below 2 gives error code 2 with `done` in the cycle after `start`, and no byte is accepted.
- R8: `done` is high for exactly one cycle. `pass` is 1 exactly when `err_code` is 0. After a failure all four section outputs read zero. After reset `done`, `pass`, `err_code` and `in_ready` are 0.
- R9: `in_ready` is high only while the image is being loaded, and exactly len bytes are accepted. A `start` pulse that arrives while a load or check is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new image when idle |
| img_len | input | ADDR_W+1 | Image length in bytes, sampled with start |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | 0 ok, 1 CRC, 2 header bounds, 3 alignment, 4 section bounds |
| code_off | output | 32 | Resolved code section offset |
| code_size | output | 24 | Code section size |
| data_off | output | 32 | Resolved data section offset |
| data_size | output | 24 | Data section size |

## Verification
The hardest case to reach is an image that has a valid checksum and fails only a later check. The stimulus for that case needs several things at once: a correct trailer, a valid header, and a section that is misaligned or ends one word past the image. The bench therefore builds each image in a byte array from a table of header values, computes its checksum independently, and writes the trailer last. Some table entries combine two faults, so the reporting priority is checked as well. A load is also driven with gaps in the stream and with a stray `start` pulse partway through.

// File: rtl/fwchk_pkg.sv
package fwchk_pkg;

    localparam int OFF_W      = 32;
    localparam int FLD_W      = 24;
    localparam int PRI_SHIFT  = 12;
    localparam int PRI_LOC    = 8;
    localparam int HDR_BASE   = 'h300;
    localparam int HDR_PAD    = 4;
    localparam int FLD_BYTES  = 3;
    localparam int HDR_FIELDS = 4;
    localparam int HDR_BYTES  = HDR_PAD + FLD_BYTES * HDR_FIELDS;
    localparam int FETCH_N    = 2 + FLD_BYTES * HDR_FIELDS;
    localparam int HDR_W      = 8 * FLD_BYTES * HDR_FIELDS;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'h0000;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_CRC   = 3'd1,
        ERR_HDR   = 3'd2,
        ERR_ALIGN = 3'd3,
        ERR_RANGE = 3'd4
    } fw_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CRC,
        ST_ISSUE,
        ST_TAKE,
        ST_HDR,
        ST_SECT,
        ST_DONE
    } fw_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] data_size;
        logic [FLD_W-1:0] data_off;
        logic [FLD_W-1:0] code_size;
        logic [FLD_W-1:0] code_off;
    } sec_hdr_t;

    typedef struct packed {
        fw_err_e          err;
        logic [OFF_W-1:0] code_off;
        logic [FLD_W-1:0] code_size;
        logic [OFF_W-1:0] data_off;
        logic [FLD_W-1:0] data_size;
    } fw_result_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    // true when the span [off, off+n) lies inside an image of lim bytes
    function automatic logic span_fits(input logic [OFF_W-1:0] off,
                                       input logic [OFF_W-1:0] n,
                                       input logic [OFF_W-1:0] lim);
        logic [OFF_W:0] s;
        s = {1'b0, off} + {1'b0, n};
        return s <= {1'b0, lim};
    endfunction

    function automatic fw_result_t resolve(input sec_hdr_t h,
                                           input logic [OFF_W-1:0] base,
                                           input logic [OFF_W-1:0] lim);
        fw_result_t r;
        logic [OFF_W-1:0] co, cs, dof, ds;
        co  = OFF_W'(h.code_off) + base;
        cs  = OFF_W'(h.code_size);
        dof = OFF_W'(h.data_off) + base;
        ds  = OFF_W'(h.data_size);
        r = '0;
        if (cs[1:0] != 2'b00)            r.err = ERR_ALIGN;
        else if (!span_fits(co, cs, lim)) r.err = ERR_RANGE;
        else if (ds[1:0] != 2'b00)       r.err = ERR_ALIGN;
        else if (!span_fits(dof, ds, lim)) r.err = ERR_RANGE;
        else begin
            r.err       = ERR_NONE;
            r.code_off  = co;
            r.code_size = h.code_size;
            r.data_off  = dof;
            r.data_size = h.data_size;
        end
        return r;
    endfunction

endpackage

// File: rtl/fwchk_ram.sv
module fwchk_ram #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/fwchk_crc.sv
module fwchk_crc
    import fwchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= CRC_INIT;
        else if (en)    crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/fwchk_ctrl.sv
module fwchk_ctrl
    import fwchk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  img_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [ADDR_W-1:0] ram_raddr,
    input  logic [7:0]        ram_rdata,
    output logic              crc_clr,
    output logic              crc_en,
    input  logic [15:0]       crc_val,
    output logic              done,
    output logic              pass,
    output fw_result_t        result
);
    fw_state_e        state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [3:0]       rd_cnt_q;
    logic [15:0]      trl_q;
    logic [15:0]      base_sr_q;
    logic [HDR_W-1:0] hdr_sr_q;
    logic [OFF_W-1:0] base_q;
    logic [OFF_W-1:0] base_now;
    logic [OFF_W-1:0] lim;
    logic             accept;
    fw_result_t       sect_res;

    assign in_ready  = (state_q == ST_LOAD);
    assign accept    = in_ready && in_valid;
    assign ram_we    = accept;
    assign ram_waddr = cnt_q[ADDR_W-1:0];
    assign crc_clr   = (state_q == ST_IDLE) && start;
    assign crc_en    = accept && (cnt_q < (len_q - LEN_W'(2)));
    assign done      = (state_q == ST_DONE);
    assign lim       = OFF_W'(len_q);
    assign base_now  = OFF_W'(base_sr_q) << PRI_SHIFT;
    assign sect_res  = resolve(sec_hdr_t'(hdr_sr_q), base_q, lim);

    // read address: base word bytes first, then the header fields past the pad
    always_comb begin
        if (rd_cnt_q < 4'd2)
            ram_raddr = ADDR_W'(PRI_LOC) + ADDR_W'(rd_cnt_q);
        else
            ram_raddr = base_q[ADDR_W-1:0] + ADDR_W'(HDR_BASE + HDR_PAD)
                      + ADDR_W'(rd_cnt_q) - ADDR_W'(2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            len_q     <= '0;
            cnt_q     <= '0;
            rd_cnt_q  <= '0;
            trl_q     <= '0;
            base_sr_q <= '0;
            hdr_sr_q  <= '0;
            base_q    <= '0;
            pass      <= 1'b0;
            result    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q  <= img_len;
                        cnt_q  <= '0;
                        pass   <= 1'b0;
                        result <= '0;
                        if (img_len < LEN_W'(2)) begin
                            result.err <= ERR_HDR;
                            state_q    <= ST_DONE;
                        end else begin
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                        if (cnt_q == len_q - LEN_W'(2)) trl_q[15:8] <= in_data;
                        if (cnt_q == len_q - LEN_W'(1)) begin
                            trl_q[7:0] <= in_data;
                            state_q    <= ST_CRC;
                        end
                    end
                end
                ST_CRC: begin
                    rd_cnt_q <= '0;
                    if (crc_val != trl_q) begin
                        result.err <= ERR_CRC;
                        state_q    <= ST_DONE;
                    end else if (!span_fits(OFF_W'(PRI_LOC), OFF_W'(2), lim)) begin
                        result.err <= ERR_HDR;
                        state_q    <= ST_DONE;
                    end else begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_TAKE;
                ST_TAKE: begin
                    if (rd_cnt_q < 4'd2) base_sr_q <= {ram_rdata, base_sr_q[15:8]};
                    else                 hdr_sr_q  <= {ram_rdata, hdr_sr_q[HDR_W-1:8]};
                    if (rd_cnt_q == 4'd1) begin
                        state_q <= ST_HDR;
                    end else if (rd_cnt_q == 4'(FETCH_N - 1)) begin
                        state_q <= ST_SECT;
                    end else begin
                        rd_cnt_q <= rd_cnt_q + 4'd1;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_HDR: begin
                    base_q <= base_now;
                    if (!span_fits(base_now + OFF_W'(HDR_BASE), OFF_W'(HDR_BYTES), lim)) begin
                        result.err <= ERR_HDR;
                        state_q    <= ST_DONE;
                    end else begin
                        rd_cnt_q <= 4'd2;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_SECT: begin
                    result  <= sect_res;
                    pass    <= (sect_res.err == ERR_NONE);
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fw_image_checker.sv
module fw_image_checker
    import fwchk_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ADDR_W:0]          img_len,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    output logic                     in_ready,
    output logic                     done,
    output logic                     pass,
    output logic [2:0]               err_code,
    output logic [31:0]              code_off,
    output logic [23:0]              code_size,
    output logic [31:0]              data_off,
    output logic [23:0]              data_size
);
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [ADDR_W-1:0] ram_raddr;
    logic [7:0]        ram_rdata;
    logic              crc_clr;
    logic              crc_en;
    logic [15:0]       crc_val;
    fw_result_t        result;

    fwchk_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (in_data),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    fwchk_crc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (in_data),
        .crc (crc_val)
    );

    fwchk_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .img_len   (img_len),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata),
        .crc_clr   (crc_clr),
        .crc_en    (crc_en),
        .crc_val   (crc_val),
        .done      (done),
        .pass      (pass),
        .result    (result)
    );

    assign err_code  = result.err;
    assign code_off  = result.code_off;
    assign code_size = result.code_size;
    assign data_off  = result.data_off;
    assign data_size = result.data_size;
endmodule

// File: rtl/fw_image_checker_sva.sv
module fw_image_checker_sva #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W:0]   img_len,
    input logic              in_valid,
    input logic              in_ready,
    input logic              done,
    input logic              pass,
    input logic [2:0]        err_code,
    input logic [31:0]       code_off,
    input logic [23:0]       code_size,
    input logic [31:0]       data_off,
    input logic [23:0]       data_size
);
    logic            idle_q;
    logic [ADDR_W:0] len_c;
    logic [ADDR_W:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
            len_c  <= '0;
            acc_q  <= '0;
        end else begin
            if (idle_q && start) begin
                idle_q <= 1'b0;
                len_c  <= img_len;
                acc_q  <= '0;
            end else begin
                if (done) idle_q <= 1'b1;
                if (in_valid && in_ready) acc_q <= acc_q + 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_PASS_CODE: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass == (err_code == 3'd0))); // R8
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> (code_off == 0 && code_size == 0 && data_off == 0 && data_size == 0)); // R8
    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code <= 3'd4)); // R6
    AST_SIZE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (code_size[1:0] == 2'b00 && data_size[1:0] == 2'b00)); // R4
    AST_SECT_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> ({1'b0, code_off} + 33'(code_size) <= 33'(len_c)
                         && {1'b0, data_off} + 33'(data_size) <= 33'(len_c))); // R5
    AST_SHORT_IMAGE: assert property (@(posedge clk) disable iff (rst)
        (idle_q && start && img_len < 2) |=> (done && err_code == 3'd2)); // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        idle_q |-> !in_ready); // R9
    AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (done && len_c >= 2) |-> (acc_q == len_c)); // R9
endmodule

bind fw_image_checker fw_image_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .img_len   (img_len),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .done      (done),
    .pass      (pass),
    .err_code  (err_code),
    .code_off  (code_off),
    .code_size (code_size),
    .data_off  (data_off),
    .data_size (data_size)
);

// File: tb/tb_fw_image_checker.sv
`timescale 1ns/1ps
module tb_fw_image_checker;

    localparam int ADDR_W = 10;
    localparam int CAP    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W:0]   img_len = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready, done, pass;
    logic [2:0]        err_code;
    logic [31:0]       code_off, data_off;
    logic [23:0]       code_size, data_size;

    always #2 clk = ~clk;

    fw_image_checker #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .start(start), .img_len(img_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .done(done), .pass(pass), .err_code(err_code),
        .code_off(code_off), .code_size(code_size),
        .data_off(data_off), .data_size(data_size)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] base;
        logic [23:0] co;
        logic [23:0] cs;
        logic [23:0] dof;
        logic [23:0] ds;
        logic        bad_crc;
        logic [2:0]  exp_err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'd1024, 16'd0, 24'h10,     24'h100, 24'h200, 24'h40, 1'b0, 3'd0}, // R3 pass
        '{16'd1024, 16'd0, 24'h10,     24'h100, 24'h200, 24'h40, 1'b1, 3'd1}, // R1 bad crc
        '{16'd783,  16'd0, 24'h0,      24'h0,   24'h0,   24'h0,  1'b0, 3'd2}, // R2 header one short
        '{16'd800,  16'd0, 24'h0,      24'h320, 24'h310, 24'h10, 1'b0, 3'd0}, // R5 exact end
        '{16'd1024, 16'd1, 24'h0,      24'h0,   24'h0,   24'h0,  1'b0, 3'd2}, // R2 relocated header
        '{16'd1024, 16'd0, 24'h10,     24'h102, 24'h200, 24'h40, 1'b0, 3'd3}, // R4 code size
        '{16'd1024, 16'd0, 24'h300,    24'h104, 24'h0,   24'h40, 1'b0, 3'd4}, // R5 code range
        '{16'd1024, 16'd0, 24'h10,     24'h100, 24'h200, 24'h6,  1'b0, 3'd3}, // R4 data size
        '{16'd1024, 16'd0, 24'h10,     24'h100, 24'h3F0, 24'h14, 1'b0, 3'd4}, // R5 data range
        '{16'd1024, 16'd0, 24'h10,     24'h102, 24'h200, 24'h40, 1'b1, 3'd1}, // R6 crc first
        '{16'd1024, 16'd0, 24'h10,     24'h102, 24'h3F0, 24'h14, 1'b0, 3'd3}, // R6 align first
        '{16'd1024, 16'd0, 24'h3FC,    24'h8,   24'h10,  24'h2,  1'b0, 3'd4}, // R6 code range first
        '{16'd9,    16'd0, 24'h0,      24'h0,   24'h0,   24'h0,  1'b0, 3'd2}, // R2 word short
        '{16'd12,   16'd0, 24'h0,      24'h0,   24'h0,   24'h0,  1'b0, 3'd2}, // R2 tiny image
        '{16'd1024, 16'd0, 24'hFFFFFF, 24'h4,   24'h0,   24'h0,  1'b0, 3'd4}, // R5 no wrap
        '{16'd1024, 16'd0, 24'h3FC,    24'h4,   24'h3FC, 24'h4,  1'b0, 3'd0}  // R5 both at end
    };

    int errors = 0;
    int checks = 0;
    logic [7:0] img [CAP];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c ^= {img[i], 8'h00};
            for (int k = 0; k < 8; k++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic put24(input int at, input logic [23:0] v);
        img[at]     = v[7:0];
        img[at + 1] = v[15:8];
        img[at + 2] = v[23:16];
    endtask

    task automatic build(input vec_t v);
        logic [15:0] c;
        for (int i = 0; i < CAP; i++) img[i] = 8'((i * 7 + 3) & 8'hFF);
        img[8] = v.base[7:0];
        img[9] = v.base[15:8];
        put24('h304, v.co);
        put24('h307, v.cs);
        put24('h30A, v.dof);
        put24('h30D, v.ds);
        c = ref_crc(int'(v.len) - 2);
        if (v.bad_crc) c ^= 16'h0001;
        img[int'(v.len) - 2] = c[15:8];
        img[int'(v.len) - 1] = c[7:0];
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        start   = 1'b1;
        img_len = (ADDR_W+1)'(len);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic stream(input int len, input bit gaps, input bit inject);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = img[i];
            if (inject && i == 100) begin
                start   = 1'b1;
                img_len = '0;
            end
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, tag, done, 1);
    endtask

    task automatic run_vec(input int idx, input bit gaps, input bit inject);
        vec_t v = VECS[idx];
        string tag;
        logic [31:0] eco, edo;
        logic [23:0] ecs, eds;
        bit ok = (v.exp_err == 3'd0);
        eco = ok ? (32'(v.co) + (32'(v.base) << 12)) : 32'd0;
        edo = ok ? (32'(v.dof) + (32'(v.base) << 12)) : 32'd0;
        ecs = ok ? v.cs : 24'd0;
        eds = ok ? v.ds : 24'd0;
        build(v);
        pulse_start(int'(v.len));
        stream(int'(v.len), gaps, inject);
        $sformat(tag, "R9 vec%0d ready low after load", idx);
        check(in_ready == 1'b0, tag, in_ready, 0);
        $sformat(tag, "R6 vec%0d done", idx);
        wait_done(tag);
        $sformat(tag, "R6 vec%0d err_code", idx);
        check(err_code == v.exp_err, tag, err_code, v.exp_err);
        $sformat(tag, "R8 vec%0d pass", idx);
        check(pass == ok, tag, pass, ok);
        $sformat(tag, "R3 vec%0d code_off", idx);
        check(code_off == eco, tag, code_off, eco);
        $sformat(tag, "R3 vec%0d sizes", idx);
        check(code_size == ecs && data_size == eds, tag, {code_size, data_size}, {ecs, eds});
        $sformat(tag, "R3 vec%0d data_off", idx);
        check(data_off == edo, tag, data_off, edo);
        @(negedge clk);
        $sformat(tag, "R8 vec%0d done one cycle", idx);
        check(done == 1'b0, tag, done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 / R9 reset state
        check(done == 1'b0 && pass == 1'b0, "R8 reset done/pass", {done, pass}, 0);
        check(err_code == 3'd0, "R8 reset err_code", err_code, 0);
        check(in_ready == 1'b0, "R9 reset in_ready", in_ready, 0);

        // R7 lengths below two
        for (int l = 0; l < 2; l++) begin
            pulse_start(l);
            check(done == 1'b1, "R7 short image done next cycle", done, 1);
            check(err_code == 3'd2, "R7 short image code", err_code, 2);
            check(in_ready == 1'b0, "R7 short image no byte accepted", in_ready, 0);
            @(negedge clk);
            check(done == 1'b0, "R8 short image pulse", done, 0);
        end

        // table walk: R1..R6
        for (int i = 0; i < NV; i++) run_vec(i, (i % 2) == 1, 1'b0);

        // R9 stray start during load is ignored
        run_vec(0, 1'b0, 1'b1);
        check(pass == 1'b1, "R9 start while busy ignored", pass, 1);

        // R1 back-to-back after a failure uses a fresh checksum
        run_vec(1, 1'b0, 1'b0);
        run_vec(15, 1'b1, 1'b0);
        check(pass == 1'b1, "R1 checksum cleared between images", pass, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule